// File: doc/BRIEF.md
# Processor status and mode controller

This block keeps the program status word of a processor core: four condition
flags, a sticky saturation flag, the two interrupt-disable bits, the
compact-instruction-set state bit and a five-bit operating-mode field. Three
kinds of request can change the word: software writes (either the whole word
or only the mode field), exception entries (abort, fast interrupt, normal
interrupt, undefined instruction, supervisor call) and exception returns that
reload a previously saved word.

Software writes are filtered by privilege. From user mode only the flags can
be written. In any privileged mode the whole word may be written, but a mode
value that is not one of the seven legal encodings is refused and reported by
a one-cycle pulse. Exception entries bypass the privilege filter. They force
the target mode and the interrupt masks with a fixed priority. The current
mode, the two masks and a privileged indication are presented as registered
outputs, so every accepted change is visible one clock after the request.

Top module: `psw_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge the word becomes 0x001A6000: supervisor mode (10011), both interrupt-disable bits set, flags, saturation bit and state bit clear, and `illegal_mode_o` low.
- R2: `psw_o` places N,Z,C,V at bits 31..28, saturation at 27, normal-interrupt disable at 20, fast-interrupt disable at 19, compact-set state at 18 and the mode at 17..13; every other bit reads 0; `mode_o`, `irq_mask_o` and `fiq_mask_o` mirror those fields, and the mode is always one of user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
- R3: A whole-word write (`sw_wr_en`=1, `sw_wr_mode_only`=0) from a privileged mode with a legal mode value loads bits 31..27 and 20..13 of `sw_wr_data` on the next edge.
- R4: In user mode a software write changes only bits 31..27; the masks, state bit and mode keep their values; a mode-only write changes nothing; `illegal_mode_o` stays low.
- R5: A privileged write whose mode bits are not legal leaves the mode unchanged, still loads the other fields of a whole-word write, and raises `illegal_mode_o` for the one cycle after that write.
- R6: A mode-only write (`sw_wr_mode_only`=1) from a privileged mode changes only the mode field, taken from `sw_wr_data[17:13]`.
- R7: An accepted abort, normal-interrupt, undefined-instruction or supervisor-call entry sets the mode to 10111, 10010, 11011 or 10011, sets the normal-interrupt disable, clears the state bit and keeps the flags and the fast-interrupt disable.
- R8: An accepted fast-interrupt entry sets mode 10001 and sets both interrupt-disable bits.
- R9: With several requests in one cycle the winner is abort, then fast interrupt, then normal interrupt, then undefined instruction, then supervisor call.
- R10: A fast-interrupt request is ignored while bit 19 is set; a normal-interrupt request is ignored while bit 20 is set or the mode is fast interrupt; the other three requests are always accepted.
- R11: An accepted exception entry overrides an exception return and a software write presented in the same cycle.
- R12: An exception return (`ret_en`) loads bits 31..27 and 20..13 of `ret_data` in one cycle regardless of mode and takes precedence over a software write; an illegal mode value in it keeps the current mode and pulses `illegal_mode_o`.
- R13: `sat_set` sets the saturation bit on the next edge; it stays set until a write or return clears it, and `sat_set` wins over a clear in the same cycle.
- R14: `priv_o` is high in every mode except user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write request |
| sw_wr_mode_only | input | 1 | 1: write only the mode field; 0: whole word |
| sw_wr_data | input | 32 | Software write value |
| ret_en | input | 1 | Exception return request |
| ret_data | input | 32 | Saved status word to restore |
| req_abt | input | 1 | Abort entry request |
| req_fiq | input | 1 | Fast interrupt entry request |
| req_irq | input | 1 | Normal interrupt entry request |
| req_und | input | 1 | Undefined-instruction entry request |
| req_svc | input | 1 | Supervisor-call entry request |
| sat_set | input | 1 | Sets the sticky saturation flag |
| psw_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode field |
| irq_mask_o | output | 1 | Normal-interrupt disable |
| fiq_mask_o | output | 1 | Fast-interrupt disable |
| priv_o | output | 1 | High when not in user mode |
| illegal_mode_o | output | 1 | One-cycle pulse for a refused mode value |

## Verification
The bench builds the block with its package defaults: a 32-bit word, a five-bit mode field and five exception sources. Those values make all seven mode encodings and all 32 mode patterns reachable, so directed sequences can walk every entry from every relevant mode and random traffic can hit illegal encodings, simultaneous requests and return-versus-write collisions. A behavioural model tracks the word every cycle, and directed steps pin each priority and masking corner to literal values.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W    = 32;
    localparam int MODE_W   = 5;
    localparam int NFLAG    = 4;
    localparam int N_EXC    = 5;

    localparam int FLAG_LO  = 28;
    localparam int SAT_BIT  = 27;
    localparam int IRQD_BIT = 20;
    localparam int FIQD_BIT = 19;
    localparam int CST_BIT  = 18;
    localparam int MODE_LO  = 13;
    localparam int MODE_HI  = MODE_LO + MODE_W - 1;

    // Index in the request vector is also the priority (0 wins).
    localparam int IDX_ABT = 0;
    localparam int IDX_FIQ = 1;
    localparam int IDX_IRQ = 2;
    localparam int IDX_UND = 3;
    localparam int IDX_SVC = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic [NFLAG-1:0] nzcv;
        logic             sat;
        logic             irq_dis;
        logic             fiq_dis;
        logic             cset;
        mode_e            mode;
    } psw_t;

    localparam psw_t PSW_RESET = '{nzcv: '0, sat: 1'b0, irq_dis: 1'b1,
                                   fiq_dis: 1'b1, cset: 1'b0, mode: MODE_SVC};

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic [PSW_W-1:0] psw_pack(input psw_t p);
        logic [PSW_W-1:0] w;
        w = '0;
        w[FLAG_LO +: NFLAG]  = p.nzcv;
        w[SAT_BIT]           = p.sat;
        w[IRQD_BIT]          = p.irq_dis;
        w[FIQD_BIT]          = p.fiq_dis;
        w[CST_BIT]           = p.cset;
        w[MODE_LO +: MODE_W] = p.mode;
        return w;
    endfunction

    function automatic mode_e entry_mode(input int idx);
        case (idx)
            IDX_ABT: return MODE_ABT;
            IDX_FIQ: return MODE_FIQ;
            IDX_IRQ: return MODE_IRQ;
            IDX_UND: return MODE_UND;
            default: return MODE_SVC;
        endcase
    endfunction

endpackage

// File: rtl/psw_prio_pick.sv
module psw_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psw_exc_apply.sv
module psw_exc_apply
    import psw_pkg::*;
#(
    parameter int N = N_EXC
) (
    input  psw_t         cur,
    input  logic [N-1:0] gnt,
    output psw_t         nxt
);
    always_comb begin
        nxt = cur;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                nxt.mode    = entry_mode(i);
                nxt.irq_dis = 1'b1;
                nxt.cset    = 1'b0;
                if (i == IDX_FIQ) nxt.fiq_dis = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psw_sw_path.sv
module psw_sw_path
    import psw_pkg::*;
(
    input  psw_t             cur,
    input  logic             ret_en,
    input  logic [PSW_W-1:0] ret_data,
    input  logic             wr_en,
    input  logic             wr_mode_only,
    input  logic [PSW_W-1:0] wr_data,
    output psw_t             nxt,
    output logic             illegal
);
    logic [MODE_W-1:0] ret_mode;
    logic [MODE_W-1:0] wr_mode;
    logic              in_user;

    assign ret_mode = ret_data[MODE_HI:MODE_LO];
    assign wr_mode  = wr_data[MODE_HI:MODE_LO];
    assign in_user  = (cur.mode == MODE_USR);

    always_comb begin
        nxt     = cur;
        illegal = 1'b0;
        if (ret_en) begin
            nxt.nzcv    = ret_data[FLAG_LO +: NFLAG];
            nxt.sat     = ret_data[SAT_BIT];
            nxt.irq_dis = ret_data[IRQD_BIT];
            nxt.fiq_dis = ret_data[FIQD_BIT];
            nxt.cset    = ret_data[CST_BIT];
            if (mode_is_legal(ret_mode)) nxt.mode = mode_e'(ret_mode);
            else                         illegal  = 1'b1;
        end else if (wr_en) begin
            if (in_user) begin
                if (!wr_mode_only) begin
                    nxt.nzcv = wr_data[FLAG_LO +: NFLAG];
                    nxt.sat  = wr_data[SAT_BIT];
                end
            end else begin
                if (!wr_mode_only) begin
                    nxt.nzcv    = wr_data[FLAG_LO +: NFLAG];
                    nxt.sat     = wr_data[SAT_BIT];
                    nxt.irq_dis = wr_data[IRQD_BIT];
                    nxt.fiq_dis = wr_data[FIQD_BIT];
                    nxt.cset    = wr_data[CST_BIT];
                end
                if (mode_is_legal(wr_mode)) nxt.mode = mode_e'(wr_mode);
                else                        illegal  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr_en,
    input  logic              sw_wr_mode_only,
    input  logic [PSW_W-1:0]  sw_wr_data,
    input  logic              ret_en,
    input  logic [PSW_W-1:0]  ret_data,
    input  logic              req_abt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_und,
    input  logic              req_svc,
    input  logic              sat_set,
    output logic [PSW_W-1:0]  psw_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o,
    output logic              priv_o,
    output logic              illegal_mode_o
);
    psw_t             psw_q;
    psw_t             psw_d;
    psw_t             exc_nxt;
    psw_t             sw_nxt;
    logic             sw_illegal;
    logic             illegal_q;
    logic             priv_q;
    logic [N_EXC-1:0] req_vec;
    logic [N_EXC-1:0] gnt;
    logic             exc_any;

    // Request gating against the current masks and mode.
    always_comb begin
        req_vec          = '0;
        req_vec[IDX_ABT] = req_abt;
        req_vec[IDX_FIQ] = req_fiq && !psw_q.fiq_dis;
        req_vec[IDX_IRQ] = req_irq && !psw_q.irq_dis && (psw_q.mode != MODE_FIQ);
        req_vec[IDX_UND] = req_und;
        req_vec[IDX_SVC] = req_svc;
    end

    psw_prio_pick #(.N(N_EXC)) i_pick (
        .req (req_vec),
        .gnt (gnt),
        .any (exc_any)
    );

    psw_exc_apply #(.N(N_EXC)) i_exc (
        .cur (psw_q),
        .gnt (gnt),
        .nxt (exc_nxt)
    );

    psw_sw_path i_sw (
        .cur          (psw_q),
        .ret_en       (ret_en),
        .ret_data     (ret_data),
        .wr_en        (sw_wr_en),
        .wr_mode_only (sw_wr_mode_only),
        .wr_data      (sw_wr_data),
        .nxt          (sw_nxt),
        .illegal      (sw_illegal)
    );

    always_comb begin
        psw_d     = exc_any ? exc_nxt : sw_nxt;
        psw_d.sat = psw_d.sat | sat_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q     <= PSW_RESET;
            illegal_q <= 1'b0;
            priv_q    <= 1'b1;
        end else begin
            psw_q     <= psw_d;
            illegal_q <= sw_illegal && !exc_any;
            priv_q    <= (psw_d.mode != MODE_USR);
        end
    end

    assign psw_o          = psw_pack(psw_q);
    assign mode_o         = psw_q.mode;
    assign irq_mask_o     = psw_q.irq_dis;
    assign fiq_mask_o     = psw_q.fiq_dis;
    assign priv_o         = priv_q;
    assign illegal_mode_o = illegal_q;
endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk
    import psw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sw_wr_en,
    input logic              ret_en,
    input logic              req_abt,
    input logic              req_fiq,
    input logic              req_irq,
    input logic              req_und,
    input logic              req_svc,
    input logic              sat_set,
    input logic [PSW_W-1:0]  psw_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              irq_mask_o,
    input logic              fiq_mask_o,
    input logic              priv_o,
    input logic              illegal_mode_o
);
    logic prev_rst;
    always_ff @(posedge clk) prev_rst <= rst;

    p_reset_word_r1: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (psw_o == 32'h001A_6000 && !illegal_mode_o));

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
        mode_is_legal(mode_o));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (psw_o & ~32'hF81F_E000) == 32'h0);

    p_user_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_USR && !req_abt && !req_fiq && !req_irq && !req_und
         && !req_svc && !ret_en)
        |=> (mode_o == MODE_USR && $stable(irq_mask_o) && $stable(fiq_mask_o)));

    p_illegal_keeps_mode_r5: assert property (@(posedge clk) disable iff (rst)
        illegal_mode_o |-> $stable(mode_o));

    p_fiq_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (req_fiq && !req_abt && !fiq_mask_o)
        |=> (mode_o == MODE_FIQ && irq_mask_o && fiq_mask_o));

    p_abort_first_r9: assert property (@(posedge clk) disable iff (rst)
        req_abt |=> (mode_o == MODE_ABT && irq_mask_o && !illegal_mode_o));

    p_irq_blocked_in_fiq_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_FIQ && req_irq && !req_abt && !req_fiq && !req_und
         && !req_svc && !ret_en && !sw_wr_en)
        |=> (mode_o == MODE_FIQ));

    p_sat_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        sat_set |=> psw_o[SAT_BIT]);

    p_priv_flag_r14: assert property (@(posedge clk) disable iff (rst)
        priv_o == (mode_o != MODE_USR));
endmodule

bind psw_ctrl psw_ctrl_chk i_psw_ctrl_chk (
    .clk            (clk),
    .rst            (rst),
    .sw_wr_en       (sw_wr_en),
    .ret_en         (ret_en),
    .req_abt        (req_abt),
    .req_fiq        (req_fiq),
    .req_irq        (req_irq),
    .req_und        (req_und),
    .req_svc        (req_svc),
    .sat_set        (sat_set),
    .psw_o          (psw_o),
    .mode_o         (mode_o),
    .irq_mask_o     (irq_mask_o),
    .fiq_mask_o     (fiq_mask_o),
    .priv_o         (priv_o),
    .illegal_mode_o (illegal_mode_o)
);

// File: tb/test_psw_ctrl.sv
module test_psw_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_wr_en = 1'b0, sw_wr_mode_only = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic        ret_en = 1'b0;
    logic [31:0] ret_data = '0;
    logic        req_abt = 1'b0, req_fiq = 1'b0, req_irq = 1'b0;
    logic        req_und = 1'b0, req_svc = 1'b0, sat_set = 1'b0;
    logic [31:0] psw_o;
    logic [4:0]  mode_o;
    logic        irq_mask_o, fiq_mask_o, priv_o, illegal_mode_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_on   = 1'b0;
    bit    finished = 1'b0;
    string phase    = "R1";

    // Reference state
    logic [31:0] m_psw = 32'h001A_6000;
    logic        m_ill = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_ctrl i_psw_ctrl (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_mode_only(sw_wr_mode_only),
        .sw_wr_data(sw_wr_data), .ret_en(ret_en), .ret_data(ret_data),
        .req_abt(req_abt), .req_fiq(req_fiq), .req_irq(req_irq), .req_und(req_und),
        .req_svc(req_svc), .sat_set(sat_set), .psw_o(psw_o), .mode_o(mode_o),
        .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o), .priv_o(priv_o),
        .illegal_mode_o(illegal_mode_o)
    );

    function automatic bit legal(input logic [4:0] m);
        return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
               m == 5'h17 || m == 5'h1B || m == 5'h1F;
    endfunction

    // Behavioural model, advanced once per rising edge.
    always @(posedge clk) begin
        logic [31:0] nw;
        logic [4:0]  cm;
        bit          ill;
        bit          taken;
        nw = m_psw; cm = m_psw[17:13]; ill = 1'b0; taken = 1'b1;
        if (rst) begin
            nw = 32'h001A_6000;
        end else begin
            if (req_abt)                                    nw[17:13] = 5'b10111;
            else if (req_fiq && !m_psw[19])                 nw[17:13] = 5'b10001;
            else if (req_irq && !m_psw[20] && cm != 5'h11)  nw[17:13] = 5'b10010;
            else if (req_und)                               nw[17:13] = 5'b11011;
            else if (req_svc)                               nw[17:13] = 5'b10011;
            else taken = 1'b0;
            if (taken) begin
                nw[20] = 1'b1;
                nw[18] = 1'b0;
                if (nw[17:13] == 5'b10001) nw[19] = 1'b1;
            end else if (ret_en) begin
                nw = ret_data & 32'hF81F_E000;
                if (!legal(ret_data[17:13])) begin nw[17:13] = cm; ill = 1'b1; end
            end else if (sw_wr_en) begin
                if (cm == 5'h10) begin
                    if (!sw_wr_mode_only) nw[31:27] = sw_wr_data[31:27];
                end else begin
                    if (!sw_wr_mode_only) nw = sw_wr_data & 32'hF81F_E000;
                    if (legal(sw_wr_data[17:13])) nw[17:13] = sw_wr_data[17:13];
                    else begin nw[17:13] = cm; ill = 1'b1; end
                end
            end
            if (sat_set) nw[27] = 1'b1;
        end
        m_psw = nw;
        m_ill = ill;
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            n_checks++;
            if (psw_o !== m_psw || illegal_mode_o !== m_ill || mode_o !== m_psw[17:13] ||
                irq_mask_o !== m_psw[20] || fiq_mask_o !== m_psw[19] ||
                priv_o !== (m_psw[17:13] != 5'h10)) begin
                n_fail++;
                $display("FAIL %s model compare: psw=%h ill=%b priv=%b expected psw=%h ill=%b priv=%b",
                         phase, psw_o, illegal_mode_o, priv_o, m_psw, m_ill,
                         (m_psw[17:13] != 5'h10));
            end
        end
    end

    task automatic idle();
        sw_wr_en = 0; sw_wr_mode_only = 0; sw_wr_data = '0; ret_en = 0; ret_data = '0;
        req_abt = 0; req_fiq = 0; req_irq = 0; req_und = 0; req_svc = 0; sat_set = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input bit mo);
        sw_wr_en = 1; sw_wr_mode_only = mo; sw_wr_data = d;
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset word", psw_o, 32'h001A_6000);
        chk("R1 reset illegal", {31'b0, illegal_mode_o}, 32'h0);
        chk("R14 priv in supervisor", {31'b0, priv_o}, 32'h1);
        rst = 0;
        cmp_on = 1;

        phase = "R3";
        wr(32'hA907_EFFF, 0);
        chk("R3 whole write, R2 reserved bits zero", psw_o, 32'hA807_E000);
        chk("R2 mode_o mirror", {27'b0, mode_o}, 32'h1F);

        phase = "R6";
        wr(32'hFFFE_5FFF, 1);
        chk("R6 mode-only write", psw_o, 32'hA806_4000);

        phase = "R5";
        wr(32'h5010_0000, 0);
        chk("R5 illegal mode kept, fields written", psw_o, 32'h5012_4000);
        chk("R5 illegal pulse", {31'b0, illegal_mode_o}, 32'h1);
        step();
        chk("R5 pulse one cycle", {31'b0, illegal_mode_o}, 32'h0);

        phase = "R13";
        sat_set = 1; step();
        chk("R13 sat set", psw_o, 32'h5812_4000);
        step();
        chk("R13 sat sticky", psw_o, 32'h5812_4000);
        sat_set = 1; wr(32'h5012_4000, 0);
        chk("R13 set wins over clear", psw_o, 32'h5812_4000);
        wr(32'h5012_4000, 0);
        chk("R13 write clears", psw_o, 32'h5012_4000);

        phase = "R4";
        wr(32'h0002_0000, 0);
        chk("R4 enter user", psw_o, 32'h0002_0000);
        chk("R14 priv low in user", {31'b0, priv_o}, 32'h0);
        wr(32'hF81E_6000, 0);
        chk("R4 user write flags only", psw_o, 32'hF802_0000);
        wr(32'h0003_E000, 1);
        chk("R4 user mode-only write ignored", psw_o, 32'hF802_0000);
        wr(32'h0000_0000, 0);
        chk("R4 user illegal write flags only", psw_o, 32'h0002_0000);
        chk("R4 no illegal pulse in user", {31'b0, illegal_mode_o}, 32'h0);

        phase = "R7";
        req_svc = 1; step();
        chk("R7 supervisor call entry", psw_o, 32'h0012_6000);
        phase = "R10";
        req_irq = 1; step();
        chk("R10 irq masked ignored", psw_o, 32'h0012_6000);
        wr(32'h000A_6000, 0);
        req_fiq = 1; step();
        chk("R10 fiq masked ignored", psw_o, 32'h000A_6000);
        phase = "R7";
        req_irq = 1; step();
        chk("R7 irq entry", psw_o, 32'h001A_4000);

        phase = "R8";
        wr(32'h0002_6000, 0);
        req_fiq = 1; step();
        chk("R8 fiq entry", psw_o, 32'h001A_2000);
        phase = "R10";
        wr(32'h0002_2000, 0);
        req_irq = 1; step();
        chk("R10 irq ignored in fiq mode", psw_o, 32'h0002_2000);
        phase = "R7";
        req_und = 1; step();
        chk("R7 undefined entry", psw_o, 32'h0013_6000);
        req_abt = 1; step();
        chk("R7 abort entry", psw_o, 32'h0012_E000);

        phase = "R9";
        wr(32'h0003_E000, 0);
        req_abt = 1; req_fiq = 1; req_irq = 1; req_und = 1; req_svc = 1; step();
        chk("R9 abort wins", psw_o, 32'h0012_E000);
        wr(32'h0003_E000, 0);
        req_fiq = 1; req_irq = 1; req_und = 1; req_svc = 1; step();
        chk("R9 fiq over irq", psw_o, 32'h001A_2000);
        wr(32'h0003_E000, 0);
        req_irq = 1; req_und = 1; req_svc = 1; step();
        chk("R9 irq over undefined", psw_o, 32'h0012_4000);
        wr(32'h0003_E000, 0);
        req_und = 1; req_svc = 1; step();
        chk("R9 undefined over svc", psw_o, 32'h0013_6000);

        phase = "R11";
        wr(32'h0003_E000, 0);
        req_svc = 1; ret_en = 1; ret_data = 32'hF002_0000;
        sw_wr_en = 1; sw_wr_data = 32'h5000_0000; step();
        chk("R11 entry beats return and write", psw_o, 32'h0012_6000);
        chk("R11 no illegal pulse", {31'b0, illegal_mode_o}, 32'h0);

        phase = "R12";
        ret_en = 1; ret_data = 32'h980A_0001;
        sw_wr_en = 1; sw_wr_data = 32'h0003_E000; step();
        chk("R12 return beats write", psw_o, 32'h980A_0000);
        ret_en = 1; ret_data = 32'h0001_4000; step();
        chk("R12 illegal return keeps mode", psw_o, 32'h0002_0000);
        chk("R12 illegal return pulse", {31'b0, illegal_mode_o}, 32'h1);

        phase = "R2 random";
        for (int k = 0; k < 600; k++) begin
            logic [4:0] ms [7];
            ms = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
            sw_wr_en        = ($urandom % 3) == 0;
            sw_wr_mode_only = ($urandom % 3) == 0;
            sw_wr_data      = $urandom;
            if (($urandom % 4) != 0) sw_wr_data[17:13] = ms[$urandom % 7];
            ret_en          = ($urandom % 8) == 0;
            ret_data        = $urandom;
            if (($urandom % 4) != 0) ret_data[17:13] = ms[$urandom % 7];
            req_abt = ($urandom % 16) == 0;
            req_fiq = ($urandom % 8) == 0;
            req_irq = ($urandom % 6) == 0;
            req_und = ($urandom % 16) == 0;
            req_svc = ($urandom % 10) == 0;
            sat_set = ($urandom % 8) == 0;
            rst     = ($urandom % 97) == 0;
            @(posedge clk); #1;
        end
        rst = 0;
        idle();
        step();
        finish_run();
    end
endmodule